// File: doc/BRIEF.md
# Addressed Packet Router

This block sits between a host serial link and a radio link and steers length-prefixed packets between them and a local command handler. Each packet opens with a count byte that gives how many bytes follow it. Next come a 16-bit destination address and a 16-bit source address, both high byte first. Then comes a command byte, and after it up to 120 payload bytes. Each of the two ingress sides collects a whole packet into its own buffer before it judges the header. A good packet is then replayed unchanged to one of three egress streams. Malformed packets are dropped whole.

The node's own address arrives on a plain input. A promiscuous monitor mode decides whether radio traffic for other nodes reaches the host. The local command stream can change that mode. Every byte stream uses valid/ready: a byte moves on a clock edge where both are high, and a sender that raises valid keeps data and last steady until the byte is taken. While an ingress side is replaying a packet it holds its ready low. A stalled egress stream therefore pushes back on the side that feeds it and on no other.

Top module: `pkt_router`

## Requirements
- R1: A count byte below 5 or above 125 makes the whole packet be dropped. All of its announced bytes are still consumed. No egress stream ever starts a packet with a count outside 5..125.
- R2: A command byte below 0xA0 or above 0xDF makes the packet be dropped whole.
- R3: A host-side packet whose destination equals `own_id` is sent to the local stream.
- R4: A host-side packet with any other destination, address 0 included, is sent to the radio egress stream.
- R5: A radio-side packet with destination 0 goes to the host egress stream, whatever its command.
- R6: A radio-side packet addressed to `own_id` goes to the local stream when its command is 0xA0..0xBF. It goes to the host egress stream when its command is 0xC0..0xDF.
- R7: A radio-side packet for any other address is discarded while monitor mode is off. It goes to the host egress stream while monitor mode is on.
- R8: Monitor mode is off after reset. It turns on when a packet with command 0xA6 finishes on the local stream. It turns off when one with 0xA7 finishes there. It changes at no other time.
- R9: A packet is forwarded only after all of its bytes have arrived, with every byte in its original order. While it waits or is stalled, the egress valid, data and last hold steady, and the feeding ingress ready stays low.
- R10: If a started packet sees no new byte for GAP_LIM cycles, the partial packet is discarded without setting the error flag, and the next byte is taken as a fresh count byte.
- R11: Both sides may target the local stream at once. It then carries whole packets one at a time and never interleaves bytes. When both wait, the side not served last goes next.
- R12: `err_flag` is low after reset. It rises on the first packet dropped under R1 or R2 and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_id | input | 16 | This node's address |
| host_in_valid | input | 1 | Host ingress byte valid |
| host_in_data | input | 8 | Host ingress byte |
| host_in_ready | output | 1 | Host ingress can take a byte |
| radio_in_valid | input | 1 | Radio ingress byte valid |
| radio_in_data | input | 8 | Radio ingress byte |
| radio_in_ready | output | 1 | Radio ingress can take a byte |
| host_out_valid | output | 1 | Host egress byte valid |
| host_out_data | output | 8 | Host egress byte |
| host_out_last | output | 1 | Final byte of the host egress packet |
| host_out_ready | input | 1 | Host egress sink can take a byte |
| radio_out_valid | output | 1 | Radio egress byte valid |
| radio_out_data | output | 8 | Radio egress byte |
| radio_out_last | output | 1 | Final byte of the radio egress packet |
| radio_out_ready | input | 1 | Radio egress sink can take a byte |
| local_out_valid | output | 1 | Local command byte valid |
| local_out_data | output | 8 | Local command byte |
| local_out_last | output | 1 | Final byte of the local packet |
| local_out_ready | input | 1 | Local handler can take a byte |
| monitor_on | output | 1 | Monitor mode state |
| err_flag | output | 1 | Sticky malformed-packet flag |

## Verification
The local stream is the one place where the two ingress sides meet. Both of them can hold a finished packet for it in the same cycle. The bench provokes this by stalling the local sink. It then completes a host packet and a radio packet, both addressed to this node, and releases the stall. Both packets must arrive whole, in arbitration order, with signatures equal to the ones computed from the stimulus. A second collision happens when a packet that changes the mode finishes on the local stream just as a radio packet for another node is being judged. The bench keeps the two in strict order and checks the filtering of the packet that follows.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;

  typedef enum logic [1:0] {
    RT_DROP  = 2'd0,
    RT_LOCAL = 2'd1,
    RT_RADIO = 2'd2,
    RT_HOST  = 2'd3
  } route_e;

  localparam logic [7:0] CMD_REQ_LO = 8'hA0;
  localparam logic [7:0] CMD_RSP_LO = 8'hC0;
  localparam logic [7:0] CMD_HI     = 8'hDF;
  localparam logic [7:0] CMD_MON_ON = 8'hA6;
  localparam logic [7:0] CMD_MON_OFF = 8'hA7;

  function automatic route_e pick_route(input logic from_radio,
                                        input logic [15:0] dest,
                                        input logic [15:0] own,
                                        input logic [7:0] cmd,
                                        input logic mon);
    if (!from_radio) return (dest == own) ? RT_LOCAL : RT_RADIO;
    if (dest == 16'd0) return RT_HOST;
    if (dest == own) return (cmd < CMD_RSP_LO) ? RT_LOCAL : RT_HOST;
    return mon ? RT_HOST : RT_DROP;
  endfunction

endpackage

// File: rtl/pr_ingress.sv
module pr_ingress
  import pkt_router_pkg::*;
#(
  parameter bit FROM_RADIO = 1'b0,
  parameter int MIN_LEN    = 5,
  parameter int MAX_LEN    = 125,
  parameter int GAP_LIM    = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] own_id,
  input  logic        mon,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  output route_e      out_route,
  output logic [7:0]  out_cmd,
  input  logic        out_ready,
  output logic        bad_pkt
);
  localparam int DEPTH = MAX_LEN + 1;
  localparam int AW    = $clog2(DEPTH);
  localparam int GW    = $clog2(GAP_LIM + 1);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_CHECK, S_SEND} st_e;

  st_e            st;
  logic [7:0]     buf_q [DEPTH];
  logic [7:0]     len_q;
  logic [7:0]     idx_q;
  logic [AW-1:0]  rd_q;
  logic [GW-1:0]  gap_q;
  route_e         route_q;
  logic           take, wr_en;
  logic [AW-1:0]  wr_idx;
  logic [15:0]    dest_w;
  logic           hdr_ok;
  route_e         route_w;

  assign in_ready = (st == S_IDLE) || (st == S_RECV);
  assign take     = in_valid && in_ready;
  assign wr_en    = take && ((st == S_IDLE) || (idx_q < 8'(DEPTH)));
  assign wr_idx   = (st == S_IDLE) ? '0 : idx_q[AW-1:0];

  assign dest_w  = {buf_q[1], buf_q[2]};
  assign out_cmd = buf_q[5];
  assign hdr_ok  = (len_q >= 8'(MIN_LEN)) && (len_q <= 8'(MAX_LEN)) &&
                   (buf_q[5] >= CMD_REQ_LO) && (buf_q[5] <= CMD_HI);
  assign route_w = pick_route(FROM_RADIO, dest_w, own_id, buf_q[5], mon);

  assign out_valid = (st == S_SEND);
  assign out_data  = buf_q[rd_q];
  assign out_last  = (8'(rd_q) == len_q);
  assign out_route = route_q;

  always_ff @(posedge clk) begin
    if (wr_en) buf_q[wr_idx] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      len_q   <= '0;
      idx_q   <= '0;
      rd_q    <= '0;
      gap_q   <= '0;
      route_q <= RT_DROP;
      bad_pkt <= 1'b0;
    end else begin
      bad_pkt <= 1'b0;
      unique case (st)
        S_IDLE: begin
          gap_q <= '0;
          if (take) begin
            len_q <= in_data;
            idx_q <= 8'd1;
            st    <= (in_data == 8'd0) ? S_CHECK : S_RECV;
          end
        end
        S_RECV: begin
          if (take) begin
            gap_q <= '0;
            idx_q <= idx_q + 8'd1;
            if (idx_q == len_q) st <= S_CHECK;
          end else if (gap_q == GW'(GAP_LIM - 1)) begin
            st <= S_IDLE;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        S_CHECK: begin
          rd_q <= '0;
          if (!hdr_ok) begin
            bad_pkt <= 1'b1;
            st      <= S_IDLE;
          end else if (route_w == RT_DROP) begin
            st <= S_IDLE;
          end else begin
            route_q <= route_w;
            st      <= S_SEND;
          end
        end
        S_SEND: begin
          if (out_ready) begin
            rd_q <= rd_q + 1'b1;
            if (out_last) st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pr_local_arb.sv
module pr_local_arb #(
  parameter int NSRC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      req_v,
  input  logic [NSRC-1:0][7:0] req_d,
  input  logic [NSRC-1:0]      req_l,
  output logic [NSRC-1:0]      req_rdy,
  output logic                 out_v,
  output logic [7:0]           out_d,
  output logic                 out_l,
  input  logic                 out_rdy,
  output logic                 sel_o
);
  logic busy_q, sel_q, prio_q;

  assign sel_o = sel_q;
  assign out_v = busy_q && req_v[sel_q];
  assign out_d = req_d[sel_q];
  assign out_l = req_l[sel_q];

  always_comb begin
    req_rdy = '0;
    if (busy_q) req_rdy[sel_q] = out_rdy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
      prio_q <= 1'b0;
    end else if (!busy_q) begin
      if (req_v != '0) begin
        busy_q <= 1'b1;
        sel_q  <= req_v[prio_q] ? prio_q : ~prio_q;
      end
    end else if (out_v && out_rdy && out_l) begin
      busy_q <= 1'b0;
      prio_q <= ~sel_q;
    end
  end
endmodule

// File: rtl/pkt_router.sv
module pkt_router
  import pkt_router_pkg::*;
#(
  parameter int MIN_LEN = 5,
  parameter int MAX_LEN = 125,
  parameter int GAP_LIM = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] own_id,
  input  logic        host_in_valid,
  input  logic [7:0]  host_in_data,
  output logic        host_in_ready,
  input  logic        radio_in_valid,
  input  logic [7:0]  radio_in_data,
  output logic        radio_in_ready,
  output logic        host_out_valid,
  output logic [7:0]  host_out_data,
  output logic        host_out_last,
  input  logic        host_out_ready,
  output logic        radio_out_valid,
  output logic [7:0]  radio_out_data,
  output logic        radio_out_last,
  input  logic        radio_out_ready,
  output logic        local_out_valid,
  output logic [7:0]  local_out_data,
  output logic        local_out_last,
  input  logic        local_out_ready,
  output logic        monitor_on,
  output logic        err_flag
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0]      in_v, in_r, o_v, o_l, o_r, bad, loc_req, loc_rdy;
  logic [NSIDE-1:0][7:0] in_d, o_d, o_cmd;
  route_e                o_rt [NSIDE];
  logic                  arb_sel;
  logic                  mon_q, err_q;

  assign in_v = {radio_in_valid, host_in_valid};
  assign in_d = {radio_in_data, host_in_data};
  assign host_in_ready  = in_r[0];
  assign radio_in_ready = in_r[1];

  for (genvar gi = 0; gi < NSIDE; gi++) begin : g_side
    pr_ingress #(
      .FROM_RADIO(gi == 1), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .GAP_LIM(GAP_LIM)
    ) u_ing (
      .clk(clk), .rst_n(rst_n), .own_id(own_id), .mon(mon_q),
      .in_valid(in_v[gi]), .in_data(in_d[gi]), .in_ready(in_r[gi]),
      .out_valid(o_v[gi]), .out_data(o_d[gi]), .out_last(o_l[gi]),
      .out_route(o_rt[gi]), .out_cmd(o_cmd[gi]), .out_ready(o_r[gi]),
      .bad_pkt(bad[gi])
    );
    assign loc_req[gi] = o_v[gi] && (o_rt[gi] == RT_LOCAL);
    if (gi == 0) begin : g_host
      assign o_r[gi] = (o_rt[gi] == RT_LOCAL) ? loc_rdy[gi] : radio_out_ready;
    end else begin : g_radio
      assign o_r[gi] = (o_rt[gi] == RT_LOCAL) ? loc_rdy[gi] : host_out_ready;
    end
  end

  assign radio_out_valid = o_v[0] && (o_rt[0] == RT_RADIO);
  assign radio_out_data  = o_d[0];
  assign radio_out_last  = o_l[0];
  assign host_out_valid  = o_v[1] && (o_rt[1] == RT_HOST);
  assign host_out_data   = o_d[1];
  assign host_out_last   = o_l[1];

  pr_local_arb #(.NSRC(NSIDE)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req_v(loc_req), .req_d(o_d), .req_l(o_l), .req_rdy(loc_rdy),
    .out_v(local_out_valid), .out_d(local_out_data), .out_l(local_out_last),
    .out_rdy(local_out_ready), .sel_o(arb_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (bad != '0) err_q <= 1'b1;
      if (local_out_valid && local_out_ready && local_out_last) begin
        if (o_cmd[arb_sel] == CMD_MON_ON)  mon_q <= 1'b1;
        if (o_cmd[arb_sel] == CMD_MON_OFF) mon_q <= 1'b0;
      end
    end
  end

  assign monitor_on = mon_q;
  assign err_flag   = err_q;
endmodule

// File: rtl/pkt_router_chk.sv
module pkt_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_in_ready,
  input logic       radio_in_ready,
  input logic       host_out_valid,
  input logic [7:0] host_out_data,
  input logic       host_out_last,
  input logic       host_out_ready,
  input logic       radio_out_valid,
  input logic [7:0] radio_out_data,
  input logic       radio_out_last,
  input logic       radio_out_ready,
  input logic       local_out_valid,
  input logic [7:0] local_out_data,
  input logic       local_out_last,
  input logic       local_out_ready,
  input logic       monitor_on,
  input logic       err_flag
);
  logic loc_first, host_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_first  <= 1'b1;
      host_first <= 1'b1;
    end else begin
      if (local_out_valid && local_out_ready) loc_first <= local_out_last;
      if (host_out_valid && host_out_ready) host_first <= host_out_last;
    end
  end

  p_local_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    local_out_valid && !local_out_ready |=>
      local_out_valid && $stable(local_out_data) && $stable(local_out_last));
  p_host_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_out_valid && !host_out_ready |=>
      host_out_valid && $stable(host_out_data) && $stable(host_out_last));
  p_radio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    radio_out_valid && !radio_out_ready |=>
      radio_out_valid && $stable(radio_out_data) && $stable(radio_out_last));
  p_host_in_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    radio_out_valid |-> !host_in_ready);
  p_radio_in_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_out_valid |-> !radio_in_ready);
  p_local_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    local_out_valid && loc_first |-> local_out_data >= 8'd5 && local_out_data <= 8'd125);
  p_host_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_out_valid && host_first |-> host_out_data >= 8'd5 && host_out_data <= 8'd125);
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  p_mon_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(local_out_valid && local_out_ready && local_out_last) |-> $stable(monitor_on));
endmodule

bind pkt_router pkt_router_chk u_chk (.*);

// File: tb/sim_pkt_router.sv
module sim_sink (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        v,
  input  logic [7:0]  d,
  input  logic        l,
  input  logic        r,
  output int          cnt,
  output logic [31:0] sig,
  output int          nbytes
);
  logic [31:0] acc;
  int          nb;
  logic        first;
  always @(negedge clk) begin
    if (!rst_n) begin
      cnt = 0; sig = '0; nbytes = 0; acc = '0; nb = 0; first = 1'b1;
    end else if (v && r) begin
      acc = first ? 32'(d) : acc * 32'd31 + 32'(d);
      nb  = first ? 1 : nb + 1;
      first = l;
      if (l) begin
        cnt = cnt + 1; sig = acc; nbytes = nb;
      end
    end
  end
endmodule

module sim_pkt_router;
  localparam logic [15:0] OWN = 16'h1234;
  localparam logic [15:0] SRC_H = 16'h5678;
  localparam logic [15:0] SRC_R = 16'h9ABC;
  localparam int GAP = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       hiv = 0, riv = 0, hor = 1, ror = 1, lor = 1;
  logic [7:0] hid = 0, rid = 0;
  logic       hir, rir, hov, hol, rov, rol, lov, lol, mon, err;
  logic [7:0] hod, rod, lod;

  pkt_router #(.GAP_LIM(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .own_id(OWN),
    .host_in_valid(hiv), .host_in_data(hid), .host_in_ready(hir),
    .radio_in_valid(riv), .radio_in_data(rid), .radio_in_ready(rir),
    .host_out_valid(hov), .host_out_data(hod), .host_out_last(hol), .host_out_ready(hor),
    .radio_out_valid(rov), .radio_out_data(rod), .radio_out_last(rol), .radio_out_ready(ror),
    .local_out_valid(lov), .local_out_data(lod), .local_out_last(lol), .local_out_ready(lor),
    .monitor_on(mon), .err_flag(err)
  );

  int          c_h, c_r, c_l, n_h, n_r, n_l;
  logic [31:0] s_h, s_r, s_l;
  sim_sink k_h (.clk(clk), .rst_n(rst_n), .v(hov), .d(hod), .l(hol), .r(hor), .cnt(c_h), .sig(s_h), .nbytes(n_h));
  sim_sink k_r (.clk(clk), .rst_n(rst_n), .v(rov), .d(rod), .l(rol), .r(ror), .cnt(c_r), .sig(s_r), .nbytes(n_r));
  sim_sink k_l (.clk(clk), .rst_n(rst_n), .v(lov), .d(lod), .l(lol), .r(lor), .cnt(c_l), .sig(s_l), .nbytes(n_l));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // dst: 0 none, 1 local, 2 radio out, 3 host out
  typedef struct packed {
    logic        side;
    logic [7:0]  len;
    logic [15:0] dest;
    logic [7:0]  cmd;
    logic [1:0]  dst;
    logic        err;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{1'b0, 8'd5,   16'h1234, 8'hA0, 2'd1, 1'b0},  // R3
    '{1'b0, 8'd8,   16'h0042, 8'hA1, 2'd2, 1'b0},  // R4
    '{1'b0, 8'd5,   16'h0000, 8'hC0, 2'd2, 1'b0},  // R4 broadcast out
    '{1'b1, 8'd5,   16'h0000, 8'hA3, 2'd3, 1'b0},  // R5
    '{1'b1, 8'd6,   16'h1234, 8'hA2, 2'd1, 1'b0},  // R6 request
    '{1'b1, 8'd7,   16'h1234, 8'hC4, 2'd3, 1'b0},  // R6 reply
    '{1'b1, 8'd5,   16'h0077, 8'hA0, 2'd0, 1'b0},  // R7 drop
    '{1'b0, 8'd4,   16'h1234, 8'hA0, 2'd0, 1'b1},  // R1 short
    '{1'b0, 8'd126, 16'h1234, 8'hA0, 2'd0, 1'b1},  // R1 long
    '{1'b1, 8'd5,   16'h1234, 8'h9F, 2'd0, 1'b1},  // R2 low
    '{1'b1, 8'd5,   16'h1234, 8'hE0, 2'd0, 1'b1},  // R2 high
    '{1'b0, 8'd125, 16'h1234, 8'hBF, 2'd1, 1'b1},  // R1 max, R3
    '{1'b1, 8'd5,   16'h1234, 8'hDF, 2'd3, 1'b1},  // R6 top reply
    '{1'b1, 8'd5,   16'h1234, 8'hBF, 2'd1, 1'b1}   // R6 top request
  };

  function automatic logic [7:0] pbyte(int i, logic [7:0] len, logic [15:0] dest,
                                       logic [15:0] src, logic [7:0] cmd);
    case (i)
      0: return len;
      1: return dest[15:8];
      2: return dest[7:0];
      3: return src[15:8];
      4: return src[7:0];
      5: return cmd;
      default: return 8'(i * 7 + int'(len));
    endcase
  endfunction

  function automatic logic [31:0] psig(logic [7:0] len, logic [15:0] dest,
                                       logic [15:0] src, logic [7:0] cmd);
    logic [31:0] s = '0;
    for (int i = 0; i <= int'(len); i++) s = s * 32'd31 + 32'(pbyte(i, len, dest, src, cmd));
    return s;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(bit side, logic [7:0] b);
    if (side) begin riv = 1; rid = b; while (!rir) @(negedge clk); end
    else      begin hiv = 1; hid = b; while (!hir) @(negedge clk); end
    @(negedge clk);
  endtask

  task automatic send_pkt(bit side, logic [7:0] len, logic [15:0] dest, logic [7:0] cmd);
    for (int i = 0; i <= int'(len); i++)
      send_byte(side, pbyte(i, len, dest, side ? SRC_R : SRC_H, cmd));
    if (side) riv = 0; else hiv = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // send one packet and check where it landed
  task automatic route_chk(string req, bit side, logic [7:0] len, logic [15:0] dest,
                           logic [7:0] cmd, logic [1:0] dst);
    int bl = c_l, br = c_r, bh = c_h;
    logic [31:0] es = psig(len, dest, side ? SRC_R : SRC_H, cmd);
    send_pkt(side, len, dest, cmd);
    idle(300);
    chk(c_l == bl + (dst == 2'd1 ? 1 : 0), req, c_l - bl, dst == 2'd1);
    chk(c_r == br + (dst == 2'd2 ? 1 : 0), req, c_r - br, dst == 2'd2);
    chk(c_h == bh + (dst == 2'd3 ? 1 : 0), req, c_h - bh, dst == 2'd3);
    case (dst)
      2'd1: chk(s_l == es && n_l == int'(len) + 1, req, s_l, es);
      2'd2: chk(s_r == es && n_r == int'(len) + 1, req, s_r, es);
      2'd3: chk(s_h == es && n_h == int'(len) + 1, req, s_h, es);
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1;
    idle(2);
    // reset state, R8 R12
    chk(!hov && !rov && !lov, "R9 reset idle", {hov, rov, lov}, 0);
    chk(hir && rir, "R9 reset ready", {hir, rir}, 3);
    chk(mon == 1'b0, "R8 reset mode", mon, 0);
    chk(err == 1'b0, "R12 reset flag", err, 0);

    for (int v = 0; v < 14; v++) begin
      route_chk($sformatf("R1-6 row%0d", v), VEC[v].side, VEC[v].len, VEC[v].dest,
                VEC[v].cmd, VEC[v].dst);
      chk(err == VEC[v].err, "R12 sticky", err, VEC[v].err);
    end

    // monitor mode: R7 R8
    route_chk("R8 on", 1'b0, 8'd5, OWN, 8'hA6, 2'd1);
    chk(mon == 1'b1, "R8 mode on", mon, 1);
    route_chk("R7 monitor pass", 1'b1, 8'd9, 16'h0077, 8'hC5, 2'd3);
    route_chk("R8 off", 1'b1, 8'd5, OWN, 8'hA7, 2'd1);
    chk(mon == 1'b0, "R8 mode off", mon, 0);
    route_chk("R7 drop again", 1'b1, 8'd6, 16'h0077, 8'hC5, 2'd0);

    // gap timeout: R10
    rst_n = 0; idle(3); rst_n = 1; idle(2);
    send_byte(1'b0, 8'd6); send_byte(1'b0, 8'h12); send_byte(1'b0, 8'h34);
    hiv = 0;
    idle(GAP + 10);
    chk(c_l == 0 && !lov, "R10 partial gone", c_l, 0);
    route_chk("R10 fresh packet", 1'b0, 8'd7, OWN, 8'hA1, 2'd1);
    chk(err == 1'b0, "R10 no flag", err, 0);

    // back-pressure: R9
    lor = 0;
    send_pkt(1'b0, 8'd5, OWN, 8'hA0);
    idle(30);
    chk(lov && lod == 8'd5 && !lol, "R9 held first byte", lod, 5);
    chk(!hir, "R9 ingress blocked", hir, 0);
    chk(c_l == 1, "R9 nothing taken", c_l, 1);
    lor = 1;
    idle(40);
    chk(c_l == 2 && s_l == psig(8'd5, OWN, SRC_H, 8'hA0), "R9 released", s_l,
        psig(8'd5, OWN, SRC_H, 8'hA0));

    // same-cycle local contention: R11
    lor = 0;
    send_pkt(1'b0, 8'd5, OWN, 8'hA1);
    send_pkt(1'b1, 8'd6, OWN, 8'hA2);
    idle(10);
    chk(lov && lod == 8'd5, "R11 host granted", lod, 5);
    lor = 1;
    idle(60);
    chk(c_l == 4, "R11 both delivered", c_l, 4);
    chk(s_l == psig(8'd6, OWN, SRC_R, 8'hA2) && n_l == 7, "R11 radio intact last", s_l,
        psig(8'd6, OWN, SRC_R, 8'hA2));
    chk(hir && rir, "R11 both ready again", {hir, rir}, 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule